// File: doc/BRIEF.md
# Serial Hit-Frame Transmitter

This block turns a trigger request into one fixed-length serial frame. When `start_i` is sampled high, the current bunch-crossing count, event count, status flags, chip identifier and channel hit word are captured as one request and queued. The transmitter takes requests from the queue in order. For each request it sends three 16-bit header words, then the channel bits, then a CRC-16 over everything sent before it. Every field goes out most significant bit first. `valid_o` is high for every bit of a frame and low otherwise.

If a request is already queued when a frame ends, the next frame starts on the following cycle. `valid_o` then stays high across the boundary. A request that arrives while the queue is full is dropped, and a sticky error flag is raised. With the default 128 channel bits a frame is 192 bits long.

The controller has four states:
- IDLE: nothing is being sent.
- HDR: the 48 header bits are being sent.
- DATA: the channel bits are being sent.
- CHK: the 16 checksum bits are being sent.

Its transitions are:
- IDLE→HDR (launch): the queue is not empty.
- HDR→DATA (header done): the last header bit has been sent.
- DATA→CHK (payload done): the last channel bit has been sent.
- CHK→HDR (chain): the last frame bit has been sent and the queue is not empty.
- CHK→IDLE (drain): the last frame bit has been sent and the queue is empty.

Top module: `hitpkt_tx`

## Requirements
- R1: While reset is held and right after it, `ser_o`, `valid_o` and `ovf_o` are 0.
- R2: When `start_i` is sampled at rising edge t and the block is idle, `valid_o` is still 0 after edge t and is 1 after edge t+1, with frame bit 0 on `ser_o`.
- R3: For an isolated request, `valid_o` stays 1 for exactly FRAME_W = 48 + CH_W + 16 cycles and then returns to 0.
- R4: Frame bits 0..15 are the marker 1010 followed by the 12-bit bunch count, sent MSB first.
- R5: Frame bits 16..31 are the marker 1100, then the 8-bit event count, then the 4 flag bits, sent MSB first.
- R6: Frame bits 32..47 are the marker 1110 followed by the 12-bit chip identifier, sent MSB first.
- R7: The next CH_W bits are the channel word, sent MSB first.
- R8: The last 16 bits are a CRC-16 over all earlier frame bits in send order, sent MSB first. It uses polynomial 0x1021, preset 0xFFFF, no reflection and no final inversion.
- R9: Queued requests are sent in arrival order with no idle cycle between frames, and `valid_o` stays 1 across frame boundaries. The field values are those present when `start_i` was sampled.
- R10: A request sampled while the queue already holds QDEPTH entries is dropped and never sent. `ovf_o` then goes to 1 and stays 1 until reset. Filling the queue without exceeding it leaves `ovf_o` at 0.
- R11: `ser_o` is 0 whenever `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse, one request per sampled cycle |
| bx_i | input | 12 | Bunch-crossing count |
| evt_i | input | 8 | Event count |
| flags_i | input | 4 | Status flags |
| chip_i | input | 12 | Chip identifier |
| chan_i | input | CH_W | Channel hit word |
| ser_o | output | 1 | Serial frame data, MSB first |
| valid_o | output | 1 | High while a frame bit is on `ser_o` |
| ovf_o | output | 1 | Sticky request-queue overflow |

## Verification
The bench builds the block with CH_W = 16 and QDEPTH = 2. This makes a frame 80 bits long, so dozens of frames with arithmetically generated field values fit easily into the run. Two-entry queue exhaustion is reached with just three back-to-back requests, and true overflow with four. The header layout, marker positions, checksum and frame chaining are the same logic as with the default 128 channel bits, so the short frame exercises every state transition, including chaining from CHK straight into HDR.

// File: rtl/hitpkt_pkg.sv
package hitpkt_pkg;

    localparam int BX_W      = 12;
    localparam int EVT_W     = 8;
    localparam int FLG_W     = 4;
    localparam int CHIP_W    = 12;
    localparam int MARK_W    = 4;
    localparam int WORD_W    = 16;
    localparam int HDR_W     = 3 * WORD_W;
    localparam int CRC_W     = 16;
    localparam int META_W    = BX_W + EVT_W + FLG_W + CHIP_W;

    localparam logic [MARK_W-1:0] MARK_BX   = 4'b1010;
    localparam logic [MARK_W-1:0] MARK_EVT  = 4'b1100;
    localparam logic [MARK_W-1:0] MARK_CHIP = 4'b1110;

    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_CHK
    } tx_state_t;

endpackage

// File: rtl/hitpkt_fifo.sv
module hitpkt_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R10
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R9
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/hitpkt_crc16.sv
module hitpkt_crc16
    import hitpkt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic preset,
    input  logic upd,
    input  logic drain,
    input  logic din,
    output logic msb_o
);
    logic [CRC_W-1:0] crc;
    logic             fb;

    assign fb    = crc[CRC_W-1] ^ din;
    assign msb_o = crc[CRC_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc <= CRC_INIT;
        end else if (preset) begin
            crc <= CRC_INIT;
        end else if (upd) begin
            crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end else if (drain) begin
            crc <= {crc[CRC_W-2:0], 1'b0};
        end
    end

    // R8
    crc_mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd && drain));

endmodule

// File: rtl/hitpkt_pack.sv
module hitpkt_pack
    import hitpkt_pkg::*;
#(
    parameter int CH_W = 128
) (
    input  logic [META_W+CH_W-1:0]  req_i,
    output logic [HDR_W+CH_W-1:0]   body_o
);
    logic [BX_W-1:0]   bx;
    logic [EVT_W-1:0]  evt;
    logic [FLG_W-1:0]  flg;
    logic [CHIP_W-1:0] chip;
    logic [CH_W-1:0]   chan;

    assign {bx, evt, flg, chip, chan} = req_i;

    assign body_o = {MARK_BX, bx, MARK_EVT, evt, flg, MARK_CHIP, chip, chan};

endmodule

// File: rtl/hitpkt_tx.sv
module hitpkt_tx
    import hitpkt_pkg::*;
#(
    parameter int CH_W   = 128,
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [11:0]       bx_i,
    input  logic [7:0]        evt_i,
    input  logic [3:0]        flags_i,
    input  logic [11:0]       chip_i,
    input  logic [CH_W-1:0]   chan_i,
    output logic              ser_o,
    output logic              valid_o,
    output logic              ovf_o
);
    localparam int BODY_W  = HDR_W + CH_W;
    localparam int FRAME_W = BODY_W + CRC_W;
    localparam int REQ_W   = META_W + CH_W;
    localparam int CNT_W   = $clog2(FRAME_W);

    tx_state_t          state, state_nxt;
    logic [CNT_W-1:0]   cnt;
    logic [BODY_W-1:0]  body_sr, body_new;
    logic [REQ_W-1:0]   q_din, q_dout;
    logic               q_empty, q_full;
    logic               last, load;
    logic               crc_upd, crc_drain, crc_msb;

    assign q_din = {bx_i, evt_i, flags_i, chip_i, chan_i};

    hitpkt_fifo #(.W(REQ_W), .DEPTH(QDEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (start_i),
        .pop   (load),
        .din   (q_din),
        .dout  (q_dout),
        .empty (q_empty),
        .full  (q_full)
    );

    hitpkt_pack #(.CH_W(CH_W)) u_pack (
        .req_i  (q_dout),
        .body_o (body_new)
    );

    hitpkt_crc16 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .preset (load),
        .upd    (crc_upd),
        .drain  (crc_drain),
        .din    (body_sr[BODY_W-1]),
        .msb_o  (crc_msb)
    );

    assign last = (cnt == CNT_W'(FRAME_W - 1));
    assign load = !q_empty && ((state == ST_IDLE) || (state == ST_CHK && last));
    assign crc_upd   = (state == ST_HDR) || (state == ST_DATA);
    assign crc_drain = (state == ST_CHK);

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (!q_empty) state_nxt = ST_HDR;
            ST_HDR:  if (cnt == CNT_W'(HDR_W - 1)) state_nxt = ST_DATA;
            ST_DATA: if (cnt == CNT_W'(BODY_W - 1)) state_nxt = ST_CHK;
            ST_CHK:  if (last) state_nxt = q_empty ? ST_IDLE : ST_HDR;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // datapath: bit counter and shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            body_sr <= '0;
        end else if (load) begin
            cnt     <= '0;
            body_sr <= body_new;
        end else if (state != ST_IDLE) begin
            cnt     <= last ? '0 : cnt + 1'b1;
            body_sr <= {body_sr[BODY_W-2:0], 1'b0};
        end
    end

    // sticky overflow
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovf_o <= 1'b0;
        else if (start_i && q_full)  ovf_o <= 1'b1;
    end

    // outputs
    always_comb begin
        ser_o   = 1'b0;
        valid_o = 1'b1;
        unique case (state)
            ST_IDLE: valid_o = 1'b0;
            ST_HDR:  ser_o   = body_sr[BODY_W-1];
            ST_DATA: ser_o   = body_sr[BODY_W-1];
            ST_CHK:  ser_o   = crc_msb;
            default: valid_o = 1'b0;
        endcase
    end

    // R3
    valid_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid_o) |-> ($past(cnt) == CNT_W'(FRAME_W - 1)));

    // R8
    chk_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHK) |-> (cnt >= CNT_W'(BODY_W)));

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> !ser_o);

    // R9
    chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHK && last && !q_empty) |=> (valid_o && cnt == '0));

endmodule

// File: tb/hitpkt_tx_bench.sv
module hitpkt_tx_bench;
    localparam int CH_W  = 16;
    localparam int QD    = 2;
    localparam int BODYW = 48 + CH_W;
    localparam int FRAME = BODYW + 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [11:0] bx_i = '0;
    logic [7:0]  evt_i = '0;
    logic [3:0]  flags_i = '0;
    logic [11:0] chip_i = '0;
    logic [CH_W-1:0] chan_i = '0;
    logic ser_o, valid_o, ovf_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    hitpkt_tx #(.CH_W(CH_W), .QDEPTH(QD)) u_hitpkt_tx (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .bx_i(bx_i), .evt_i(evt_i), .flags_i(flags_i),
        .chip_i(chip_i), .chan_i(chan_i),
        .ser_o(ser_o), .valid_o(valid_o), .ovf_o(ovf_o)
    );

    typedef struct packed {
        logic [11:0] bx;
        logic [7:0]  evt;
        logic [3:0]  flg;
        logic [11:0] chip;
        logic [CH_W-1:0] chan;
    } req_t;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [FRAME-1:0] expect_frame(input req_t r);
        logic [BODYW-1:0] b;
        logic [15:0] c;
        logic fb;
        b = {4'b1010, r.bx, 4'b1100, r.evt, r.flg, 4'b1110, r.chip, r.chan};
        c = 16'hFFFF;
        for (int i = BODYW - 1; i >= 0; i--) begin
            fb = c[15] ^ b[i];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return {b, c};
    endfunction

    function automatic req_t make_req(input int k);
        req_t r;
        r.bx   = 12'(k * 173 + 5);
        r.evt  = 8'(k * 37 + 1);
        r.flg  = 4'(k * 5);
        r.chip = 12'(k * 911 + 3);
        r.chan = CH_W'(k * 40503 + 7) ^ CH_W'(k << 3);
        if (k == 0) r = '0;
        if (k == 1) r = '1;
        return r;
    endfunction

    task automatic drive(input req_t r);
        {bx_i, evt_i, flags_i, chip_i, chan_i} = r;
        start_i = 1'b1;
    endtask

    task automatic scramble();
        start_i = 1'b0;
        {bx_i, evt_i, flags_i, chip_i, chan_i} = ~{bx_i, evt_i, flags_i, chip_i, chan_i};
    endtask

    task automatic check_frame(input logic [FRAME-1:0] got, input req_t r);
        logic [FRAME-1:0] e;
        e = expect_frame(r);
        chk(got[FRAME-1 -: 16] == e[FRAME-1 -: 16], "R4 bunch word", 64'(got[FRAME-1 -: 16]), 64'(e[FRAME-1 -: 16]));
        chk(got[FRAME-17 -: 16] == e[FRAME-17 -: 16], "R5 event/flags word", 64'(got[FRAME-17 -: 16]), 64'(e[FRAME-17 -: 16]));
        chk(got[FRAME-33 -: 16] == e[FRAME-33 -: 16], "R6 chip word", 64'(got[FRAME-33 -: 16]), 64'(e[FRAME-33 -: 16]));
        chk(got[16 +: CH_W] == e[16 +: CH_W], "R7 channel bits", 64'(got[16 +: CH_W]), 64'(e[16 +: CH_W]));
        chk(got[15:0] == e[15:0], "R8 checksum", 64'(got[15:0]), 64'(e[15:0]));
    endtask

    // Collect frames starting at the current negedge; ends one negedge after the last bit.
    task automatic collect(input int nframes, input string vtag, output logic [FRAME-1:0] f [3]);
        int vlow;
        vlow = 0;
        for (int n = 0; n < nframes; n++) begin
            for (int i = 0; i < FRAME; i++) begin
                if (!valid_o) vlow++;
                f[n][FRAME-1-i] = ser_o;
                @(negedge clk);
            end
        end
        chk(vlow == 0, vtag, 64'(vlow), 64'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [FRAME-1:0] fr [3];
        req_t r, ra, rb, rc, rd;

        repeat (3) @(negedge clk);
        // R1: held in reset
        chk(!valid_o && !ser_o && !ovf_o, "R1 during reset", 64'({valid_o, ser_o, ovf_o}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!valid_o && !ser_o && !ovf_o, "R1 after reset", 64'({valid_o, ser_o, ovf_o}), 64'd0);

        // Sweep of isolated frames
        for (int k = 0; k < 24; k++) begin
            r = make_req(k);
            drive(r);
            @(negedge clk);
            scramble();
            chk(valid_o == 1'b0, "R2 valid still low after first edge", 64'(valid_o), 64'd0);
            @(negedge clk);
            chk(valid_o == 1'b1, "R2 valid high after second edge", 64'(valid_o), 64'd1);
            collect(1, "R3 valid held across frame", fr);
            check_frame(fr[0], r);
            chk(valid_o == 1'b0, "R3 valid low after FRAME cycles", 64'(valid_o), 64'd0);
            chk(ser_o == 1'b0, "R11 line idle low", 64'(ser_o), 64'd0);
            repeat (k % 3) @(negedge clk);
        end

        // R9: three back-to-back requests, queue fills but does not overflow
        ra = make_req(31); rb = make_req(32); rc = make_req(33);
        fork
            begin
                drive(ra); @(negedge clk);
                drive(rb); @(negedge clk);
                drive(rc); @(negedge clk);
                scramble();
            end
            begin
                @(negedge clk);
                @(negedge clk);
                collect(3, "R9 valid unbroken across chained frames", fr);
            end
        join
        check_frame(fr[0], ra);
        check_frame(fr[1], rb);
        check_frame(fr[2], rc);
        chk(valid_o == 1'b0, "R9 valid low after chain", 64'(valid_o), 64'd0);
        chk(ovf_o == 1'b0, "R10 no overflow at exactly full", 64'(ovf_o), 64'd0);
        repeat (2) @(negedge clk);

        // R10: fourth request overflows and is dropped
        ra = make_req(41); rb = make_req(42); rc = make_req(43); rd = make_req(44);
        fork
            begin
                drive(ra); @(negedge clk);
                drive(rb); @(negedge clk);
                drive(rc); @(negedge clk);
                drive(rd); @(negedge clk);
                scramble();
            end
            begin
                @(negedge clk);
                @(negedge clk);
                collect(3, "R9 valid unbroken under overflow", fr);
            end
        join
        check_frame(fr[0], ra);
        check_frame(fr[1], rb);
        check_frame(fr[2], rc);
        chk(valid_o == 1'b0, "R10 dropped request not sent", 64'(valid_o), 64'd0);
        chk(ovf_o == 1'b1, "R10 overflow flagged", 64'(ovf_o), 64'd1);

        // R10: flag stays set through later traffic
        r = make_req(50);
        drive(r);
        @(negedge clk);
        scramble();
        @(negedge clk);
        collect(1, "R3 valid held after overflow", fr);
        check_frame(fr[0], r);
        chk(ovf_o == 1'b1, "R10 overflow sticky", 64'(ovf_o), 64'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule